// File: doc/BRIEF.md
# Subword SIMD Integer Arithmetic Unit

This block is a two-stage pipelined integer arithmetic unit. It takes one 64-bit word that carries two 32-bit operands and a 5-bit opcode. It adds, subtracts or multiplies the operands as four 8-bit lanes, as two 16-bit lanes, or as a single 32-bit value. One set of four byte-wide processing elements produces every multiply partial product. A 64-bit adder whose carry chain can be cut at byte boundaries then finishes each operation. This arrangement serves all three widths, so no width needs its own datapath.

The first stage holds the input register, the logic that splits the operands into byte slices, and the processing elements. The second stage holds the pipeline register, the partitioned adder and the output register. A result leaves the unit a fixed number of cycles after its operands arrive, and a new operation can be accepted on every cycle.

Top module: `simd_arith_unit`

## Requirements
- R1: Operand A is `in_data[31:0]` and operand B is `in_data[63:32]`. Both are captured together on a rising edge where `in_valid` is high. Subtraction computes A minus B.
- R2: `out_valid` and the matching `out_data` appear after the second rising edge that follows the capture edge. `out_valid` copies `in_valid` with this fixed lag on every cycle, with no stalls and no gaps between back-to-back operations.
- R3: Opcode encoding. Bit 4 is 0. Bits [3:2] select the operation: 00 add, 01 subtract, 10 multiply. Bits [1:0] select the lane width: 01 is 8-bit, 10 is 16-bit, 11 is 32-bit. The valid codes are 0x01, 0x02, 0x03 (add), 0x05, 0x06, 0x07 (subtract) and 0x09, 0x0A, 0x0B (multiply).
- R4: In 8-bit add, byte lane i of the result, at bits 8i+7:8i, is the sum of byte i of A and byte i of B modulo 256. No carry crosses a byte boundary. For every add and subtract, bits 63:32 of the result are zero.
- R5: In 16-bit add, each half of the result (bits 15:0 and 31:16) is the sum of the matching A and B halves modulo 65536. A carry from bit 15 does not reach bit 16.
- R6: In 32-bit add, bits 31:0 of the result are A plus B modulo 2^32.
- R7: Subtraction at each width yields, in each lane, A minus B modulo 2^width, placed at the same position as for add.
- R8: 8-bit multiply yields four unsigned 16-bit products. The product of byte i of A and byte i of B is placed at bits 16i+15:16i.
- R9: 16-bit multiply yields two unsigned 32-bit products. The product of the low halves is placed at bits 31:0, and the product of the high halves at bits 63:32.
- R10: 32-bit multiply yields the full unsigned 64-bit product of A and B.
- R11: Any opcode not listed in R3 produces an all-zero result, with `out_valid` still asserted.
- R12: While `rst_n` is low, `out_valid` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe; operands and opcode are taken on this cycle |
| in_opcode | input | 5 | Operation and lane width code |
| in_data | input | 64 | Operand B in the upper half, operand A in the lower half |
| out_valid | output | 1 | Result strobe |
| out_data | output | 64 | Result word |

## Verification
The hardest cases to bring about from the ports are carries that would cross a lane boundary if the chain were not cut. Examples are a 16-bit sum that wraps in the low half while the high half is all ones, a borrow running through a full 32-bit lane, and the largest multiply products, where every partial product carries. Random operands seldom produce these, so the stimulus applies directed all-ones, all-zero and one-off-boundary operands at each width. Around these sit seeded random traffic with random valid gaps, random opcodes including unused codes, and back-to-back issue. Every operation in flight is therefore checked against a lane-by-lane model.

// File: rtl/simd_arith_pkg.sv
package simd_arith_pkg;

    localparam int unsigned OP_W = 5;

    localparam logic [OP_W-1:0] OPC_ADD8  = 5'h01;
    localparam logic [OP_W-1:0] OPC_ADD16 = 5'h02;
    localparam logic [OP_W-1:0] OPC_ADD32 = 5'h03;
    localparam logic [OP_W-1:0] OPC_SUB8  = 5'h05;
    localparam logic [OP_W-1:0] OPC_SUB16 = 5'h06;
    localparam logic [OP_W-1:0] OPC_SUB32 = 5'h07;
    localparam logic [OP_W-1:0] OPC_MUL8  = 5'h09;
    localparam logic [OP_W-1:0] OPC_MUL16 = 5'h0A;
    localparam logic [OP_W-1:0] OPC_MUL32 = 5'h0B;

    typedef enum logic [1:0] {K_NONE, K_ADD, K_SUB, K_MUL} kind_e;
    typedef enum logic [1:0] {W_8, W_16, W_32} width_e;

    typedef struct packed {
        kind_e  kind;
        width_e width;
    } dec_t;

    function automatic dec_t decode_op(logic [OP_W-1:0] op);
        dec_t d;
        d = '{kind: K_NONE, width: W_8};
        case (op)
            OPC_ADD8:  d = '{kind: K_ADD, width: W_8};
            OPC_ADD16: d = '{kind: K_ADD, width: W_16};
            OPC_ADD32: d = '{kind: K_ADD, width: W_32};
            OPC_SUB8:  d = '{kind: K_SUB, width: W_8};
            OPC_SUB16: d = '{kind: K_SUB, width: W_16};
            OPC_SUB32: d = '{kind: K_SUB, width: W_32};
            OPC_MUL8:  d = '{kind: K_MUL, width: W_8};
            OPC_MUL16: d = '{kind: K_MUL, width: W_16};
            OPC_MUL32: d = '{kind: K_MUL, width: W_32};
            default:   d = '{kind: K_NONE, width: W_8};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/simd_pe.sv
module simd_pe #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned N_PE   = 4
) (
    input  logic [LANE_W-1:0]        a_slice,
    input  logic [LANE_W*N_PE-1:0]   b_word,
    input  logic [N_PE-1:0]          b_sel,
    output logic [LANE_W*(N_PE+1)-1:0] row
);
    localparam int unsigned PP_W  = 2 * LANE_W;
    localparam int unsigned ROW_W = LANE_W * (N_PE + 1);

    logic [PP_W-1:0] pp [N_PE];

    for (genvar j = 0; j < N_PE; j++) begin : g_mul
        logic [LANE_W-1:0] b_gated;
        assign b_gated = b_sel[j] ? b_word[LANE_W*j +: LANE_W] : '0;
        assign pp[j]   = PP_W'(a_slice) * PP_W'(b_gated);
    end

    always_comb begin
        row = '0;
        for (int j = 0; j < N_PE; j++) begin
            row = row + (ROW_W'(pp[j]) << (LANE_W * j));
        end
    end
endmodule

// File: rtl/simd_split.sv
module simd_split
    import simd_arith_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned N_PE   = 4
) (
    input  dec_t                         dec,
    input  logic [LANE_W*N_PE-1:0]       opnd_a,
    input  logic [LANE_W*N_PE-1:0]       opnd_b,
    output logic [2*LANE_W*N_PE-1:0]     term_x,
    output logic [2*LANE_W*N_PE-1:0]     term_y,
    output logic [2*N_PE-1:0]            seg_brk,
    output logic [2*N_PE-1:0]            seg_inj
);
    localparam int unsigned OPND_W = LANE_W * N_PE;
    localparam int unsigned DATA_W = 2 * OPND_W;
    localparam int unsigned N_SEG  = 2 * N_PE;
    localparam int unsigned ROW_W  = LANE_W * (N_PE + 1);

    int unsigned lane_bytes;
    logic [N_PE-1:0]  sel  [N_PE];
    logic [ROW_W-1:0] rows [N_PE];

    always_comb begin
        case (dec.width)
            W_8:     lane_bytes = 1;
            W_16:    lane_bytes = 2;
            default: lane_bytes = N_PE;
        endcase
    end

    always_comb begin
        for (int i = 0; i < N_PE; i++) begin
            for (int j = 0; j < N_PE; j++) begin
                sel[i][j] = ((i / lane_bytes) == (j / lane_bytes));
            end
        end
    end

    for (genvar i = 0; i < N_PE; i++) begin : g_pe
        simd_pe #(.LANE_W(LANE_W), .N_PE(N_PE)) u_pe (
            .a_slice (opnd_a[LANE_W*i +: LANE_W]),
            .b_word  (opnd_b),
            .b_sel   (sel[i]),
            .row     (rows[i])
        );
    end

    always_comb begin
        term_x  = '0;
        term_y  = '0;
        seg_brk = '1;
        seg_inj = '0;
        case (dec.kind)
            K_ADD, K_SUB: begin
                term_x[OPND_W-1:0] = opnd_a;
                term_y[OPND_W-1:0] = (dec.kind == K_SUB) ? ~opnd_b : opnd_b;
                for (int k = 0; k < N_PE; k++) begin
                    seg_brk[k] = ((k % lane_bytes) == 0);
                    seg_inj[k] = (dec.kind == K_SUB) && ((k % lane_bytes) == 0);
                end
            end
            K_MUL: begin
                for (int i = 0; i < N_PE; i++) begin
                    if ((i % 2) == 0) begin
                        term_x = term_x + (DATA_W'(rows[i]) << (LANE_W * i));
                    end else begin
                        term_y = term_y + (DATA_W'(rows[i]) << (LANE_W * i));
                    end
                end
                for (int k = 0; k < N_SEG; k++) begin
                    seg_brk[k] = ((k % (2 * lane_bytes)) == 0);
                end
            end
            default: begin
                term_x = '0;
                term_y = '0;
            end
        endcase
    end
endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned N_SEG  = 8
) (
    input  logic [LANE_W*N_SEG-1:0] add_x,
    input  logic [LANE_W*N_SEG-1:0] add_y,
    input  logic [N_SEG-1:0]        brk,
    input  logic [N_SEG-1:0]        inj,
    output logic [LANE_W*N_SEG-1:0] add_sum
);
    always_comb begin : p_chain
        logic [LANE_W:0] part;
        logic            carry;
        logic            cin;
        carry   = 1'b0;
        add_sum = '0;
        for (int k = 0; k < N_SEG; k++) begin
            cin  = brk[k] ? inj[k] : carry;
            part = {1'b0, add_x[LANE_W*k +: LANE_W]}
                 + {1'b0, add_y[LANE_W*k +: LANE_W]}
                 + (LANE_W+1)'(cin);
            add_sum[LANE_W*k +: LANE_W] = part[LANE_W-1:0];
            carry = part[LANE_W];
        end
    end
endmodule

// File: rtl/simd_arith_unit.sv
module simd_arith_unit
    import simd_arith_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned N_PE   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [OP_W-1:0]            in_opcode,
    input  logic [2*LANE_W*N_PE-1:0]   in_data,
    output logic                       out_valid,
    output logic [2*LANE_W*N_PE-1:0]   out_data
);
    localparam int unsigned OPND_W = LANE_W * N_PE;
    localparam int unsigned DATA_W = 2 * OPND_W;
    localparam int unsigned N_SEG  = 2 * N_PE;

    typedef struct packed {
        logic              in_v;
        logic [OP_W-1:0]   in_op;
        logic [OPND_W-1:0] in_a;
        logic [OPND_W-1:0] in_b;
        logic              p_v;
        logic [DATA_W-1:0] p_x;
        logic [DATA_W-1:0] p_y;
        logic [N_SEG-1:0]  p_brk;
        logic [N_SEG-1:0]  p_inj;
        logic              o_v;
        logic [DATA_W-1:0] o_d;
    } state_t;

    state_t st_d, st_q;

    dec_t              dec;
    logic [DATA_W-1:0] s1_x, s1_y, s2_sum;
    logic [N_SEG-1:0]  s1_brk, s1_inj;

    assign dec = decode_op(st_q.in_op);

    simd_split #(.LANE_W(LANE_W), .N_PE(N_PE)) u_split (
        .dec     (dec),
        .opnd_a  (st_q.in_a),
        .opnd_b  (st_q.in_b),
        .term_x  (s1_x),
        .term_y  (s1_y),
        .seg_brk (s1_brk),
        .seg_inj (s1_inj)
    );

    simd_part_adder #(.LANE_W(LANE_W), .N_SEG(N_SEG)) u_add (
        .add_x   (st_q.p_x),
        .add_y   (st_q.p_y),
        .brk     (st_q.p_brk),
        .inj     (st_q.p_inj),
        .add_sum (s2_sum)
    );

    always_comb begin
        st_d      = st_q;
        st_d.in_v = in_valid;
        if (in_valid) begin
            st_d.in_op = in_opcode;
            st_d.in_a  = in_data[OPND_W-1:0];
            st_d.in_b  = in_data[DATA_W-1:OPND_W];
        end
        st_d.p_v   = st_q.in_v;
        st_d.p_x   = s1_x;
        st_d.p_y   = s1_y;
        st_d.p_brk = s1_brk;
        st_d.p_inj = s1_inj;
        st_d.o_v   = st_q.p_v;
        st_d.o_d   = s2_sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_v;
    assign out_data  = st_q.o_d;
endmodule

// File: rtl/simd_arith_chk.sv
module simd_arith_chk
    import simd_arith_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_opcode,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int unsigned HALF = DATA_W / 2;

    logic [1:0] seen_q;
    logic       unused_in, addsub_in, selfsub_in;
    dec_t       dec_in;

    assign dec_in     = decode_op(in_opcode);
    assign unused_in  = in_valid && (dec_in.kind == K_NONE);
    assign addsub_in  = in_valid && (dec_in.kind == K_ADD || dec_in.kind == K_SUB);
    assign selfsub_in = in_valid && (dec_in.kind == K_SUB)
                        && (in_data[HALF-1:0] == in_data[DATA_W-1:HALF]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(unused_in, 3)) |-> (out_valid && out_data == '0)); // R11

    AST_ADDSUB_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(addsub_in, 3)) |-> (out_data[DATA_W-1:HALF] == '0)); // R4

    AST_SUB_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(selfsub_in, 3)) |-> (out_data == '0)); // R7
endmodule

bind simd_arith_unit simd_arith_chk #(.DATA_W(2*LANE_W*N_PE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_opcode (in_opcode),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_simd_arith_unit.sv
module tb_simd_arith_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_opcode = '0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int total = 0;
    int bad   = 0;

    logic        h_v   [3];
    logic [63:0] h_d   [3];
    logic [4:0]  h_op  [3];
    string       h_req [3];

    simd_arith_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_opcode (in_opcode),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] model(logic [4:0] op, logic [31:0] a, logic [31:0] b);
        int w, kind;
        logic [127:0] r, m, sa, sb;
        kind = 0; w = 8;
        case (op)
            5'h01: begin kind = 1; w = 8;  end
            5'h02: begin kind = 1; w = 16; end
            5'h03: begin kind = 1; w = 32; end
            5'h05: begin kind = 2; w = 8;  end
            5'h06: begin kind = 2; w = 16; end
            5'h07: begin kind = 2; w = 32; end
            5'h09: begin kind = 3; w = 8;  end
            5'h0A: begin kind = 3; w = 16; end
            5'h0B: begin kind = 3; w = 32; end
            default: kind = 0;
        endcase
        r = '0;
        if (kind == 0) return 64'h0;
        m = (128'h1 << w) - 128'h1;
        for (int i = 0; i < 32 / w; i++) begin
            sa = 128'(a >> (w * i)) & m;
            sb = 128'(b >> (w * i)) & m;
            if (kind == 1)      r = r | (((sa + sb) & m) << (w * i));
            else if (kind == 2) r = r | (((sa - sb) & m) << (w * i));
            else                r = r | (((sa * sb) & ((128'h1 << (2 * w)) - 128'h1)) << (2 * w * i));
        end
        return r[63:0];
    endfunction

    function automatic string req_of(logic [4:0] op);
        case (op)
            5'h01: return "R4";
            5'h02: return "R5";
            5'h03: return "R6";
            5'h05, 5'h06, 5'h07: return "R7";
            5'h09: return "R8";
            5'h0A: return "R9";
            5'h0B: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check_out();
        total++;
        if (out_valid !== h_v[2]) begin
            bad++;
            $display("FAIL R2 out_valid got=%0b exp=%0b", out_valid, h_v[2]);
        end
        if (h_v[2]) begin
            total++;
            if (out_data !== h_d[2]) begin
                bad++;
                $display("FAIL %s op=%02h got=%016h exp=%016h", h_req[2], h_op[2], out_data, h_d[2]);
            end
        end
    endtask

    task automatic step(input logic v, input logic [4:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string req);
        @(negedge clk);
        check_out();
        for (int k = 2; k > 0; k--) begin
            h_v[k] = h_v[k-1]; h_d[k] = h_d[k-1]; h_op[k] = h_op[k-1]; h_req[k] = h_req[k-1];
        end
        in_valid  = v;
        in_opcode = op;
        in_data   = {b, a};
        h_v[0]    = v;
        h_op[0]   = op;
        h_d[0]    = model(op, a, b);
        h_req[0]  = (req == "") ? req_of(op) : req;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL R2 watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [4:0] ops [9];
        ops = '{5'h01, 5'h02, 5'h03, 5'h05, 5'h06, 5'h07, 5'h09, 5'h0A, 5'h0B};
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 3; k++) begin
            h_v[k] = 1'b0; h_d[k] = '0; h_op[k] = '0; h_req[k] = "R2";
        end
        // R12: outputs cleared while reset is held
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            total++;
            if (out_valid !== 1'b0 || out_data !== 64'h0) begin
                bad++;
                $display("FAIL R12 got=%0b/%016h exp=0/0", out_valid, out_data);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: operand order, A low half minus B high half
        step(1, 5'h07, 32'd5, 32'd3, "R1");
        step(1, 5'h07, 32'd3, 32'd5, "R1");
        // R4: byte lanes wrap without carrying into neighbours
        step(1, 5'h01, 32'hFFFF_FFFF, 32'h0101_0101, "R4");
        step(1, 5'h01, 32'h80FF_7F01, 32'h8001_01FF, "R4");
        // R5: carry from bit 15 stays in the low half
        step(1, 5'h02, 32'h0000_FFFF, 32'hFFFF_0001, "R5");
        step(1, 5'h02, 32'h1234_00FF, 32'h0001_0001, "R5");
        // R6: full 32-bit wrap
        step(1, 5'h03, 32'hFFFF_FFFF, 32'h0000_0001, "R6");
        step(1, 5'h03, 32'h0000_FFFF, 32'h0000_0001, "R6");
        // R7: borrows at each width
        step(1, 5'h05, 32'h0000_0000, 32'h0101_0101, "R7");
        step(1, 5'h06, 32'h0000_0000, 32'h0001_0001, "R7");
        step(1, 5'h07, 32'h0000_0000, 32'h0000_0001, "R7");
        step(1, 5'h07, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R7");
        // R8..R10: largest products
        step(1, 5'h09, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
        step(1, 5'h09, 32'h0102_0304, 32'h0506_0708, "R8");
        step(1, 5'h0A, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
        step(1, 5'h0A, 32'h0002_FFFF, 32'h0003_0002, "R9");
        step(1, 5'h0B, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
        step(1, 5'h0B, 32'h0001_0000, 32'h0001_0000, "R10");
        // R11, R3: unused codes give zero with valid
        step(1, 5'h00, 32'h1234_5678, 32'h9ABC_DEF0, "R11");
        step(1, 5'h1F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11");
        step(1, 5'h04, 32'hFFFF_FFFF, 32'h0000_0001, "R3");
        step(1, 5'h11, 32'hFFFF_FFFF, 32'h0000_0001, "R3");
        // R2: gap then back-to-back
        step(0, 5'h01, 32'h1, 32'h1, "R2");
        step(0, 5'h01, 32'h1, 32'h1, "R2");
        step(1, 5'h0B, 32'h7, 32'h9, "R2");

        for (int n = 0; n < 4000; n++) begin
            logic       v;
            logic [4:0] op;
            v  = ($urandom % 5) != 0;
            op = (($urandom % 10) == 0) ? 5'($urandom) : ops[$urandom % 9];
            step(v, op, $urandom, $urandom, "");
        end
        for (int n = 0; n < 4; n++) step(0, 5'h00, 32'h0, 32'h0, "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule